// File: doc/BRIEF.md
# Sticky-Collecting Mantissa Right Shifter

This block shifts a wide floating-point mantissa to the right by a signed count and keeps track of precision lost on the way. The mantissa is presented as four 32-bit words packed into one 128-bit bus. The most significant word sits in the upper bits. Every one bit that leaves the low end of the mantissa is folded into a single sticky flag. That flag starts from the sticky value supplied with the operand. Later rounding logic uses the flag to know that the truncated value was inexact.

The shift runs in two steps. A whole-word step discards 0 to 3 complete words. A funnel step then moves bits 0 to 31 places, carrying bits from each word into the next lower one. A count that reaches the parameterised mantissa width takes a shortcut: the result is all zeros and the sticky flag is forced on. The count must be positive. A count of zero or a negative count is flagged as an error, and the operand passes through unchanged. NaN payloads are shifted like any other value.

An operand is taken when the input valid and ready signals are both high. The registered result appears with the output valid signal on the next cycle. A single output register provides backpressure.

Top module: `mant_rshift`

## Requirements
- R1: Word 0 occupies inMant[127:96] and word 3 occupies inMant[31:0]. For a legal count n below MANT_BITS (115 by default), outMant equals inMant shifted right by n bits with zeros entering at the top.
- R2: For a legal count below MANT_BITS, outSticky is inSticky ORed with every one bit shifted out of the low end. It is never cleared when inSticky is 1.
- R3: For a count of MANT_BITS or more, outMant is all zeros and outSticky is 1, whatever the operand and the incoming sticky bit.
- R4: Counts of exactly 32, 64 and 96 move whole words down by one, two and three places. A zero residual leaves the moved words intact, and the dropped words feed the sticky flag.
- R5: A residual count not divisible by 32 moves the low bits of each word into the top of the next lower word. This holds for dense payloads such as an all-ones NaN mantissa.
- R6: A count of zero or less (the count is two's complement) sets outError to 1 and returns inMant and inSticky unchanged. Any legal count clears outError to 0.
- R7: outValid rises in the cycle after inValid and inReady are both high at a clock edge.
- R8: While outValid is 1 and outReady is 0, inReady is 0 and outMant, outSticky and outError hold their values.
- R9: After reset, outValid is 0 and inReady is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An operand is offered |
| inReady | output | 1 | The block can take an operand |
| inMant | input | 128 | Mantissa, word 0 in the top 32 bits |
| inSticky | input | 1 | Incoming sticky bit |
| inShift | input | 8 | Signed shift count |
| outValid | output | 1 | A result is held |
| outReady | input | 1 | The consumer takes the result |
| outMant | output | 128 | Shifted mantissa |
| outSticky | output | 1 | Updated sticky bit |
| outError | output | 1 | The count was zero or negative |

## Verification
A wrong word-select in the datapath shows up directly in the result. Word-multiple counts return misplaced words in outMant on the first result after the operand is taken. A broken funnel or sticky mask is exposed by patterns with isolated ones just below the cut line. Such a fault flips outSticky or smears bits across a word boundary, again in that first result. If the control lets the output register reload under backpressure, outMant changes while outValid is held high. That is caught within one cycle of the illegal load.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  // Strobes from the control to the datapath for one accepted operand
  typedef struct packed {
    logic load;      // capture a new result this edge
    logic bypass;    // count is zero or negative
    logic saturate;  // count reaches the mantissa width
  } mrs_strobe_t;
endpackage

// File: rtl/mrs_ctrl.sv
module mrs_ctrl
  import mrs_pkg::*;
#(
  parameter int SHIFT_W   = 8,
  parameter int MANT_BITS = 115
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [SHIFT_W-1:0] inShift,
  output logic               outValid,
  input  logic               outReady,
  output mrs_strobe_t        strobe
);
  localparam logic [SHIFT_W-1:0] LIMIT = SHIFT_W'(MANT_BITS);

  logic validQ;
  logic nonPositive;

  assign nonPositive = inShift[SHIFT_W-1] || (inShift == '0);
  assign inReady     = !validQ || outReady;

  always_comb begin
    strobe.load     = inValid && inReady;
    strobe.bypass   = nonPositive;
    strobe.saturate = !nonPositive && (inShift >= LIMIT);
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      validQ <= 1'b0;
    else if (strobe.load)
      validQ <= 1'b1;
    else if (outReady)
      validQ <= 1'b0;
  end

  assign outValid = validQ;

  assert_accept_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  assert_stall_keeps_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

  assert_strobe_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> !(strobe.bypass && strobe.saturate));
endmodule

// File: rtl/mrs_datapath.sv
module mrs_datapath
  import mrs_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 4,
  parameter int SHIFT_W   = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  mrs_strobe_t                   strobe,
  input  logic [WORD_W*NUM_WORDS-1:0]   inMant,
  input  logic                          inSticky,
  input  logic [SHIFT_W-1:0]            inShift,
  output logic [WORD_W*NUM_WORDS-1:0]   outMant,
  output logic                          outSticky,
  output logic                          outError
);
  localparam int TOTAL_W = WORD_W * NUM_WORDS;
  localparam int RES_W   = $clog2(WORD_W);
  localparam int WSEL_W  = $clog2(NUM_WORDS);

  logic [WORD_W-1:0] wordsIn  [NUM_WORDS];
  logic [WORD_W-1:0] aligned  [NUM_WORDS];
  logic [WORD_W-1:0] shifted  [NUM_WORDS];
  logic [WSEL_W-1:0] dropCount;
  logic [RES_W-1:0]  residual;
  logic              wordSticky;
  logic              funnelSticky;
  logic [WORD_W-1:0] lowMask;
  logic [TOTAL_W-1:0] shiftedFlat;

  assign dropCount = inShift[RES_W +: WSEL_W];
  assign residual  = inShift[RES_W-1:0];

  // Split the bus into words, word 0 at the top
  for (genvar i = 0; i < NUM_WORDS; i++) begin : gSplit
    assign wordsIn[i] = inMant[TOTAL_W-1-i*WORD_W -: WORD_W];
  end

  // Whole-word stage: move words down, OR the dropped ones into sticky
  always_comb begin
    wordSticky = 1'b0;
    for (int i = 0; i < NUM_WORDS; i++) aligned[i] = '0;
    for (int j = 0; j < NUM_WORDS; j++) begin
      if (j + int'(dropCount) < NUM_WORDS)
        aligned[j + int'(dropCount)] = wordsIn[j];
      else
        wordSticky = wordSticky | (|wordsIn[j]);
    end
  end

  // Residual stage: funnel each word with the one above it
  for (genvar i = 0; i < NUM_WORDS; i++) begin : gFunnel
    logic [2*WORD_W-1:0] funnel;
    if (i == 0) begin : gTop
      assign funnel = {{WORD_W{1'b0}}, aligned[i]} >> residual;
    end else begin : gLower
      assign funnel = {aligned[i-1], aligned[i]} >> residual;
    end
    assign shifted[i] = funnel[WORD_W-1:0];
    assign shiftedFlat[TOTAL_W-1-i*WORD_W -: WORD_W] = shifted[i];
  end

  assign lowMask      = ~({WORD_W{1'b1}} << residual);
  assign funnelSticky = |(aligned[NUM_WORDS-1] & lowMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outMant   <= '0;
      outSticky <= 1'b0;
      outError  <= 1'b0;
    end else if (strobe.load) begin
      if (strobe.bypass) begin
        outMant   <= inMant;
        outSticky <= inSticky;
        outError  <= 1'b1;
      end else if (strobe.saturate) begin
        outMant   <= '0;
        outSticky <= 1'b1;
        outError  <= 1'b0;
      end else begin
        outMant   <= shiftedFlat;
        outSticky <= inSticky | wordSticky | funnelSticky;
        outError  <= 1'b0;
      end
    end
  end

  assert_sticky_kept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.bypass && inSticky) |=> outSticky);

  assert_saturate_result_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.saturate) |=> (outMant == '0) && outSticky && !outError);

  assert_bypass_passthrough_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.bypass) |=> outError && (outMant == $past(inMant))
                                        && (outSticky == $past(inSticky)));

  assert_residual_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.bypass && !strobe.saturate && (inShift == SHIFT_W'(WORD_W)))
      |=> (outMant[TOTAL_W-1 -: WORD_W] == '0));
endmodule

// File: rtl/mant_rshift.sv
module mant_rshift
  import mrs_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 4,
  parameter int SHIFT_W   = 8,
  parameter int MANT_BITS = 115
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  output logic                        inReady,
  input  logic [WORD_W*NUM_WORDS-1:0] inMant,
  input  logic                        inSticky,
  input  logic [SHIFT_W-1:0]          inShift,
  output logic                        outValid,
  input  logic                        outReady,
  output logic [WORD_W*NUM_WORDS-1:0] outMant,
  output logic                        outSticky,
  output logic                        outError
);
  mrs_strobe_t strobe;

  mrs_ctrl #(.SHIFT_W(SHIFT_W), .MANT_BITS(MANT_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inShift(inShift), .outValid(outValid), .outReady(outReady), .strobe(strobe)
  );

  mrs_datapath #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .SHIFT_W(SHIFT_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inMant(inMant), .inSticky(inSticky),
    .inShift(inShift), .outMant(outMant), .outSticky(outSticky), .outError(outError)
  );

  assert_stall_holds_data_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outMant) && $stable(outSticky) && $stable(outError));

  assert_reset_idle_R9: assert property (@(posedge clk)
    !rstN |=> !outValid);
endmodule

// File: tb/mant_rshift_test.sv
module mant_rshift_test;
  localparam int PERIOD    = 10;
  localparam int MANT_BITS = 115;

  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid;
  logic         inReady;
  logic [127:0] inMant;
  logic         inSticky;
  logic [7:0]   inShift;
  logic         outValid;
  logic         outReady;
  logic [127:0] outMant;
  logic         outSticky;
  logic         outError;

  int applied = 0;
  int miscompares = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  mant_rshift uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inMant(inMant), .inSticky(inSticky), .inShift(inShift),
    .outValid(outValid), .outReady(outReady), .outMant(outMant),
    .outSticky(outSticky), .outError(outError)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    applied++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent reference from the requirements
  task automatic model(input logic [127:0] m, input logic st, input logic [7:0] sh,
                       output logic [127:0] rm, output logic rs, output logic re);
    int n;
    n = int'($signed(sh));
    if (n <= 0) begin
      rm = m; rs = st; re = 1'b1;
    end else if (n >= MANT_BITS) begin
      rm = '0; rs = 1'b1; re = 1'b0;
    end else begin
      logic [127:0] mask;
      mask = ~({128{1'b1}} << n);
      rm = m >> n; rs = st | (|(m & mask)); re = 1'b0;
    end
  endtask

  task automatic sendAndCheck(input logic [127:0] m, input logic st, input logic [7:0] sh,
                              input string req);
    logic [127:0] em;
    logic es, ee;
    model(m, st, sh, em, es, ee);
    @(negedge clk);
    inMant = m; inSticky = st; inShift = sh; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(outValid == 1'b1, {req, " R7 valid"}, 128'(outValid), 128'(1));
    check(outMant == em, {req, " mantissa"}, outMant, em);
    check(outSticky == es, {req, " sticky"}, 128'(outSticky), 128'(es));
    check(outError == ee, {req, " error R6"}, 128'(outError), 128'(ee));
  endtask

  task automatic testReset();
    check(outValid == 1'b0, "R9 outValid after reset", 128'(outValid), 128'(0));
    check(inReady == 1'b1, "R9 inReady after reset", 128'(inReady), 128'(1));
  endtask

  task automatic testBasic();
    sendAndCheck(128'h80000000_00000000_00000000_00000000, 1'b0, 8'd1, "R1 top bit by 1");
    sendAndCheck(128'h12345678_9ABCDEF0_0F0F0F0F_F0F0F0F0, 1'b0, 8'd4, "R1 nibble shift");
  endtask

  task automatic testWords();
    sendAndCheck(128'hAAAA0000_BBBB0000_CCCC0000_DDDD0000, 1'b0, 8'd32, "R4 one word");
    sendAndCheck(128'hAAAA0000_BBBB0000_CCCC0000_00000000, 1'b0, 8'd64, "R4 two words");
    sendAndCheck(128'h00010000_00000000_00000000_00000000, 1'b0, 8'd96, "R4 three words");
    sendAndCheck(128'h00010000_00000000_00000000_00000001, 1'b0, 8'd96, "R4 dropped word sticky");
  endtask

  task automatic testSticky();
    sendAndCheck(128'hFFFF0000_00000000_00000000_00000000, 1'b1, 8'd8, "R2 sticky carried");
    sendAndCheck(128'h00000001_00000000_00000000_00000010, 1'b0, 8'd4, "R2 zeros only");
    sendAndCheck(128'h00000001_00000000_00000000_00000010, 1'b0, 8'd5, "R2 one bit lost");
  endtask

  task automatic testFunnel();
    sendAndCheck(128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF, 1'b0, 8'd37, "R5 all ones");
    sendAndCheck(128'h00000003_00000000_00000000_00000000, 1'b0, 8'd33, "R5 cross word");
  endtask

  task automatic testLarge();
    sendAndCheck(128'h00040000_00000000_00000000_00000000, 1'b0, 8'd114, "R3 just below");
    sendAndCheck(128'h00040000_00000000_00000000_00000000, 1'b0, 8'd115, "R3 threshold");
    sendAndCheck(128'h0, 1'b0, 8'd127, "R3 zero operand");
  endtask

  task automatic testIllegal();
    sendAndCheck(128'hDEADBEEF_00000000_CAFEF00D_12345678, 1'b1, 8'd0, "R6 zero count");
    sendAndCheck(128'hDEADBEEF_00000000_CAFEF00D_12345678, 1'b0, 8'hFB, "R6 negative count");
    sendAndCheck(128'hDEADBEEF_00000000_CAFEF00D_12345678, 1'b0, 8'd16, "R6 legal clears error");
  endtask

  task automatic testBackpressure();
    logic [127:0] firstExp, secondExp;
    logic s1, e1, s2, e2;
    model(128'h0000FF00_00000000_00000000_00000000, 1'b0, 8'd8, firstExp, s1, e1);
    model(128'h11111111_22222222_33333333_44444444, 1'b0, 8'd40, secondExp, s2, e2);
    @(negedge clk);
    outReady = 1'b0;
    inMant = 128'h0000FF00_00000000_00000000_00000000; inSticky = 1'b0;
    inShift = 8'd8; inValid = 1'b1;
    @(negedge clk);
    inMant = 128'h11111111_22222222_33333333_44444444; inShift = 8'd40;
    check(inReady == 1'b0, "R8 inReady low while stalled", 128'(inReady), 128'(0));
    @(negedge clk);
    check(outValid == 1'b1, "R8 valid held", 128'(outValid), 128'(1));
    check(outMant == firstExp, "R8 data held", outMant, firstExp);
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(outMant == secondExp, "R7 next result after release", outMant, secondExp);
    check(outValid == 1'b1, "R7 valid after release", 128'(outValid), 128'(1));
    @(negedge clk);
    check(outValid == 1'b0, "R7 valid drops when drained", 128'(outValid), 128'(0));
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; inMant = '0; inSticky = 1'b0; inShift = '0;
    outReady = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testWords();
    testSticky();
    testFunnel();
    testLarge();
    testIllegal();
    testBackpressure();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule